// File: doc/BRIEF.md
# Periodic Interrupt and Standard-Pulse Generator

This block turns a set of time-base strobes into a periodic active-low output and a matching flag bit. A 64 Hz tick from the prescaler and the carry strobes of the seconds, minutes and hours counters arrive as one-cycle pulses. A two-bit period select picks one of them as the period event.

The output works in one of two modes. In interrupt mode an event latches the flag and holds the pin low until the host clears the flag. In standard mode an event drives the pin low for a fixed number of clock cycles, nominally half a 64 Hz period, and the pin then releases itself. The flag follows the pin in this mode. A mask input freezes the whole block. The host can write the flag to zero but can never set it.

Top module: `tick_irq_gen`

## Requirements
- R1: After synchronous reset, irq_flag is 0 and irq_n is 1.
- R2: The period select chooses the event source: 00 selects tick_64hz, 01 selects carry_sec, 10 selects carry_min and 11 selects carry_hour. A strobe on any source that is not selected changes neither output.
- R3: With irq_mode=1 and mask=0, a selected event sets irq_flag in the cycle after the event. The flag then stays set for as long as no clear arrives.
- R4: With mask=0 and no event in the same cycle, flag_clr=1 clears irq_flag in the next cycle. flag_clr never sets the flag.
- R5: With irq_mode=0 and mask=0, an event holds irq_flag at 1 for exactly PULSE_CYCLES clock cycles. The flag then returns to 0 without any clear.
- R6: In standard mode, an event that arrives while a pulse is active restarts the full PULSE_CYCLES width, counted from the new event.
- R7: In standard mode, flag_clr ends an active pulse at once.
- R8: When an event and flag_clr arrive in the same cycle, the event wins and irq_flag is 1 in the next cycle.
- R9: While mask=1, events and flag_clr are ignored and the standard-pulse countdown is frozen. Both irq_flag and irq_n keep their values.
- R10: irq_n is active low and is always the inverse of irq_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64hz | input | 1 | One-cycle strobe at 64 Hz |
| carry_sec | input | 1 | One-cycle strobe on the seconds carry |
| carry_min | input | 1 | One-cycle strobe on the minutes carry |
| carry_hour | input | 1 | One-cycle strobe on the hours carry |
| per_sel | input | 2 | Period select (see R2) |
| irq_mode | input | 1 | 1 selects interrupt mode, 0 selects standard-pulse mode |
| mask | input | 1 | 1 freezes the output and the flag |
| flag_clr | input | 1 | Host strobe that writes the flag to zero |
| irq_n | output | 1 | Active-low periodic output |
| irq_flag | output | 1 | Flag bit, set on a period event |

## Verification
The period event and the host clear can land in the same cycle, and so can the event and the end of a running standard pulse. The bench raises the selected source strobe and flag_clr on the same edge in both modes and expects the flag to be set afterwards. In standard mode the bench also expects a full fresh width to be counted from that edge. For the second case it fires a new event a few cycles into a pulse and checks that the remaining low time equals the whole width again, with no early release.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    typedef enum logic [1:0] {
        PER_64HZ = 2'b00,
        PER_SEC  = 2'b01,
        PER_MIN  = 2'b10,
        PER_HOUR = 2'b11
    } period_e;

    typedef struct packed {
        logic tick_64hz;
        logic carry_sec;
        logic carry_min;
        logic carry_hour;
    } tbase_t;

    typedef struct packed {
        period_e per;
        logic    intr_mode;
        logic    mask;
    } ctrl_t;

    typedef struct packed {
        logic hit;
        logic clear;
        logic freeze;
    } req_t;

    function automatic logic pick_source(tbase_t s, period_e p);
        logic r;
        case (p)
            PER_64HZ: r = s.tick_64hz;
            PER_SEC:  r = s.carry_sec;
            PER_MIN:  r = s.carry_min;
            default:  r = s.carry_hour;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tick_irq_src_sel.sv
module tick_irq_src_sel
    import tick_irq_pkg::*;
(
    input  tbase_t src,
    input  ctrl_t  ctrl,
    input  logic   clr_in,
    output req_t   req
);
    always_comb begin
        req.hit    = pick_source(src, ctrl.per);
        req.clear  = clr_in;
        req.freeze = ctrl.mask;
    end
endmodule

// File: rtl/tick_irq_width_timer.sv
module tick_irq_width_timer #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic freeze,
    input  logic run_en,
    output logic expire
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (freeze) begin
            cnt <= cnt;
        end else if (start && run_en) begin
            cnt <= LOAD;
        end else if (abort || !run_en) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign expire = !freeze && !start && !abort && run_en && (cnt == ONE);
endmodule

// File: rtl/tick_irq_flag_reg.sv
module tick_irq_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic freeze,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (freeze) flag <= flag;
        else if (set)    flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
    import tick_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_64hz,
    input  logic       carry_sec,
    input  logic       carry_min,
    input  logic       carry_hour,
    input  logic [1:0] per_sel,
    input  logic       irq_mode,
    input  logic       mask,
    input  logic       flag_clr,
    output logic       irq_n,
    output logic       irq_flag
);
    tbase_t src;
    ctrl_t  ctrl;
    req_t   req;
    logic   expire;
    logic   flag_q;

    assign src  = '{tick_64hz: tick_64hz, carry_sec: carry_sec,
                    carry_min: carry_min, carry_hour: carry_hour};
    assign ctrl = '{per: period_e'(per_sel), intr_mode: irq_mode, mask: mask};

    tick_irq_src_sel u_sel (
        .src    (src),
        .ctrl   (ctrl),
        .clr_in (flag_clr),
        .req    (req)
    );

    tick_irq_width_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (req.hit),
        .abort  (req.clear),
        .freeze (req.freeze),
        .run_en (!ctrl.intr_mode),
        .expire (expire)
    );

    tick_irq_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (req.hit),
        .clr    (req.clear || expire),
        .freeze (req.freeze),
        .flag   (flag_q)
    );

    assign irq_flag = flag_q;
    assign irq_n    = ~flag_q;
endmodule

// File: rtl/tick_irq_gen_chk.sv
module tick_irq_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_64hz,
    input logic       carry_sec,
    input logic       carry_min,
    input logic       carry_hour,
    input logic [1:0] per_sel,
    input logic       irq_mode,
    input logic       mask,
    input logic       flag_clr,
    input logic       irq_n,
    input logic       irq_flag
);
    logic ev;
    always_comb begin
        case (per_sel)
            2'b00:   ev = tick_64hz;
            2'b01:   ev = carry_sec;
            2'b10:   ev = carry_min;
            default: ev = carry_hour;
        endcase
    end

    // R9
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
        mask |=> $stable(irq_flag));

    // R3, R8
    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        (!mask && ev) |=> irq_flag);

    // R4, R7
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (!mask && !ev && flag_clr) |=> !irq_flag);

    // R3
    a_r3_latched: assert property (@(posedge clk) disable iff (rst)
        (irq_mode && irq_flag && !flag_clr) |=> irq_flag);

    // R2
    a_r2_rise_on_event: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(ev && !mask));

    // R10
    a_r10_pin_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $fell(irq_n));
endmodule

bind tick_irq_gen tick_irq_gen_chk u_chk (.*);

// File: tb/tick_irq_gen_bench.sv
module tick_irq_gen_bench;
    localparam int W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] srcs = '0;   // bit0 tick_64hz, bit1 sec, bit2 min, bit3 hour
    logic [1:0] per_sel = '0;
    logic irq_mode = 1'b1;
    logic mask = 1'b0;
    logic flag_clr = 1'b0;
    logic irq_n, irq_flag;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tick_irq_gen #(.PULSE_CYCLES(W)) u_tick_irq_gen (
        .clk(clk), .rst(rst),
        .tick_64hz(srcs[0]), .carry_sec(srcs[1]),
        .carry_min(srcs[2]), .carry_hour(srcs[3]),
        .per_sel(per_sel), .irq_mode(irq_mode), .mask(mask),
        .flag_clr(flag_clr), .irq_n(irq_n), .irq_flag(irq_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire(input int s, input logic clr);
        srcs[s] = 1'b1;
        flag_clr = clr;
        @(negedge clk);
        srcs = '0;
        flag_clr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic measure(output int cnt);
        cnt = 0;
        while (irq_flag && cnt < 100) begin
            if (irq_n != 1'b0) check("R10", irq_n, 0);
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int w;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 flag", irq_flag, 0);
        check("R1 pin", irq_n, 1);

        // R2, R3, R4: every select against every source, interrupt mode
        irq_mode = 1'b1;
        for (int sel = 0; sel < 4; sel++) begin
            for (int s = 0; s < 4; s++) begin
                per_sel = 2'(sel);
                fire(s, 1'b0);
                cyc(3);
                check("R2 R3 select/latch", irq_flag, (s == sel) ? 1 : 0);
                check("R10 pin", irq_n, (s == sel) ? 0 : 1);
                clear_flag();
                check("R4 clear", irq_flag, 0);
            end
        end

        // R4: clear never sets
        clear_flag();
        check("R4 clr no set", irq_flag, 0);

        // R8: collision in interrupt mode
        per_sel = 2'b01;
        fire(1, 1'b1);
        check("R8 intr collision", irq_flag, 1);
        clear_flag();

        // R5: standard width for each period source
        irq_mode = 1'b0;
        for (int sel = 0; sel < 4; sel++) begin
            per_sel = 2'(sel);
            fire(sel, 1'b0);
            measure(w);
            check("R5 width", w, W);
            check("R10 release", irq_n, 1);
        end

        // R6: restart during pulse
        per_sel = 2'b00;
        fire(0, 1'b0);
        cyc(3);
        fire(0, 1'b0);
        measure(w);
        check("R6 restart", w, W);

        // R8: collision in standard mode restarts full width
        fire(0, 1'b0);
        cyc(2);
        fire(0, 1'b1);
        measure(w);
        check("R8 std collision", w, W);

        // R7: clear ends pulse
        fire(0, 1'b0);
        cyc(2);
        clear_flag();
        check("R7 abort", irq_flag, 0);

        // R9: mask freezes countdown
        fire(0, 1'b0);
        cyc(2);
        mask = 1'b1;
        cyc(5);
        check("R9 frozen pulse", irq_flag, 1);
        mask = 1'b0;
        measure(w);
        check("R9 remaining", w, W - 2);

        // R9: mask blocks clear and event in interrupt mode
        irq_mode = 1'b1;
        per_sel = 2'b11;
        fire(3, 1'b0);
        mask = 1'b1;
        clear_flag();
        cyc(2);
        check("R9 clr ignored", irq_flag, 1);
        mask = 1'b0;
        clear_flag();
        mask = 1'b1;
        fire(3, 1'b0);
        cyc(2);
        check("R9 event ignored", irq_flag, 0);
        check("R9 pin", irq_n, 1);
        mask = 1'b0;
        cyc(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule